// File: doc/BRIEF.md
# Blit Host-Source Write Buffer

This block sits between the processor's write path and a block-transfer engine. It takes the 32-bit dwords that software writes to a source-data port and holds them in a small first-in first-out store. A pixel extractor drains that store one dword per cycle through a valid/ready handshake, so the processor and the engine run independently of each other.

A transfer starts with a one-cycle start pulse that carries the number of dwords the transfer needs. That pulse empties the store and loads a remaining-dword counter. The block stores a write only when all of these hold: a host-sourced transfer is active, the counter is nonzero, and the store has room. Writes that arrive while the store is full are lost without any error. Writes made when no transfer is active, and writes beyond the count the transfer needs, are thrown away and never reach the next transfer.

Software polls two status outputs. The half-empty flag means at least one whole 32-byte cache line of space is free. The busy flag shows that another transfer is queued behind the current one. Software must see busy clear before it streams source data.

Top module: `hsrc_fifo`

## Requirements
- R1: While reset is high and after it is released, fifo_empty and half_empty are 1, and pop_valid, fifo_full, busy and dwords_left are all 0.
- R2: Stored dwords leave on pop_data in the order they were written. pop_valid is 1 exactly when the store holds at least one dword. One dword leaves on each rising edge where pop_valid and pop_ready are both 1.
- R3: The store holds at most DEPTH dwords (default 16, that is 64 bytes). A write while fifo_full is 1 is dropped and flags nothing, even when a pop happens in the same cycle.
- R4: half_empty is 1 exactly when occupancy is at most DEPTH minus LINE_DW (default 16 - 8 = 8), so that a whole cache line of space is free.
- R5: A write while xfer_active is 0 is ignored. It changes neither the store contents nor dwords_left.
- R6: A xfer_start pulse loads dwords_left from xfer_need. Each stored write lowers dwords_left by one. A write while dwords_left is 0 is ignored, so surplus data never carries over to a later transfer.
- R7: A xfer_start pulse empties the store on that edge. It takes priority over a write or a pop in the same cycle, and fifo_empty is 1 in the next cycle.
- R8: busy is next_pend registered by one cycle.
- R9: fifo_full is 1 exactly when occupancy equals DEPTH. fifo_empty is 1 exactly when occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the source port |
| wr_data | input | 32 | Host write dword |
| xfer_start | input | 1 | One-cycle pulse that begins a transfer |
| xfer_need | input | LEFT_W | Dwords the new transfer needs, sampled with xfer_start |
| xfer_active | input | 1 | A host-sourced transfer is running |
| next_pend | input | 1 | Another transfer is queued behind the current one |
| pop_ready | input | 1 | Extractor accepts a dword |
| pop_valid | output | 1 | A dword is available |
| pop_data | output | 32 | Oldest stored dword |
| fifo_full | output | 1 | Store holds DEPTH dwords |
| fifo_empty | output | 1 | Store holds no dword |
| half_empty | output | 1 | At least one cache line of space is free |
| busy | output | 1 | Registered queued-transfer status |
| dwords_left | output | LEFT_W | Dwords the current transfer still needs |

## Verification
The assertions assume that xfer_start is a single-cycle pulse and that xfer_need is small enough that the counter never wraps. They also assume that nothing in the block is driven before reset has been applied once. The stimulus holds to these assumptions. Every start is a one-cycle pulse with a need between 0 and 40. Reset is asserted for several cycles at time zero. Random phases then change the write, ready and active rates, so the store spends time full, empty and near the half-empty threshold.

// File: rtl/hsrc_pkg.sv
package hsrc_pkg;
  localparam int unsigned DWORD_W = 32;
  typedef logic [DWORD_W-1:0] dword_t;
endpackage

// File: rtl/hsrc_gate.sv
module hsrc_gate #(
  parameter int unsigned LEFT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              xfer_start,
  input  logic [LEFT_W-1:0] xfer_need,
  input  logic              xfer_active,
  input  logic              full,
  output logic              accept,
  output logic [LEFT_W-1:0] left
);
  logic need_more;

  assign need_more = (left != '0);
  assign accept    = wr_en & xfer_active & need_more & ~full & ~xfer_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (xfer_start) begin
      left <= xfer_need;
    end else if (accept) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/hsrc_store.sv
module hsrc_store
  import hsrc_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned LINE_DW = 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned LW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  dword_t        push_data,
  input  logic          pop_ready,
  output logic          pop_valid,
  output dword_t        pop_data,
  output logic          full,
  output logic          empty,
  output logic          half,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH - LINE_DW);

  dword_t          mem [DEPTH];
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   rptr;
  logic            pop;

  assign empty     = (level == '0);
  assign full      = (level == FULL_LVL);
  assign half      = (level <= HALF_LVL);
  assign pop_valid = ~empty;
  assign pop       = pop_ready & ~empty & ~flush;
  assign pop_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/hsrc_fifo.sv
module hsrc_fifo
  import hsrc_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned LINE_DW = 8,
  parameter int unsigned LEFT_W  = 16,
  localparam int unsigned LW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              xfer_start,
  input  logic [LEFT_W-1:0] xfer_need,
  input  logic              xfer_active,
  input  logic              next_pend,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [31:0]       pop_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              half_empty,
  output logic              busy,
  output logic [LEFT_W-1:0] dwords_left
);
  logic          accept;
  logic [LW-1:0] level;

  hsrc_gate #(.LEFT_W(LEFT_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .xfer_start (xfer_start),
    .xfer_need  (xfer_need),
    .xfer_active(xfer_active),
    .full       (fifo_full),
    .accept     (accept),
    .left       (dwords_left)
  );

  hsrc_store #(.DEPTH(DEPTH), .LINE_DW(LINE_DW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (xfer_start),
    .push      (accept),
    .push_data (wr_data),
    .pop_ready (pop_ready),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .half      (half_empty),
    .level     (level)
  );

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= next_pend;
  end
endmodule

// File: rtl/hsrc_fifo_chk.sv
module hsrc_fifo_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LEFT_W = 16,
  localparam int unsigned LW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              xfer_start,
  input logic              xfer_active,
  input logic              next_pend,
  input logic              pop_ready,
  input logic              pop_valid,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              busy,
  input logic [LEFT_W-1:0] dwords_left,
  input logic [LW-1:0]     level
);
  logic pop_fire;
  assign pop_fire = pop_valid & pop_ready;

  // R3
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R3: a full store with no pop and no start stays full and grows no further
  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_full && !pop_fire && !xfer_start |=> fifo_full);

  // R5
  p_inactive_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    !xfer_active && !xfer_start && !pop_fire |=> $stable(level) && $stable(dwords_left));

  // R6
  p_surplus_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    dwords_left == '0 && !xfer_start && !pop_fire |=> $stable(level) && dwords_left == '0);

  // R6
  p_left_dec_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en && xfer_active && dwords_left != '0 && !fifo_full && !xfer_start
    |=> dwords_left == $past(dwords_left) - 1'b1);

  // R7
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> fifo_empty && !pop_valid);

  // R8
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    next_pend |=> busy);
endmodule

bind hsrc_fifo hsrc_fifo_chk #(.DEPTH(DEPTH), .LEFT_W(LEFT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .xfer_start (xfer_start),
  .xfer_active(xfer_active),
  .next_pend  (next_pend),
  .pop_ready  (pop_ready),
  .pop_valid  (pop_valid),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .busy       (busy),
  .dwords_left(dwords_left),
  .level      (level)
);

// File: tb/hsrc_fifo_tb.sv
module hsrc_fifo_tb;
  localparam int DEPTH   = 16;
  localparam int LINE_DW = 8;
  localparam int LEFT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              xfer_start = 1'b0;
  logic [LEFT_W-1:0] xfer_need = '0;
  logic              xfer_active = 1'b0;
  logic              next_pend = 1'b0;
  logic              pop_ready = 1'b0;
  logic              pop_valid;
  logic [31:0]       pop_data;
  logic              fifo_full, fifo_empty, half_empty, busy;
  logic [LEFT_W-1:0] dwords_left;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] q[$];
  int          m_left = 0;
  bit          m_busy = 1'b0;

  always #10 clk = ~clk;

  hsrc_fifo #(.DEPTH(DEPTH), .LINE_DW(LINE_DW), .LEFT_W(LEFT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_start(xfer_start), .xfer_need(xfer_need), .xfer_active(xfer_active),
    .next_pend(next_pend), .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_data(pop_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .half_empty(half_empty), .busy(busy), .dwords_left(dwords_left)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_half(int lvl);
    return lvl <= DEPTH - LINE_DW;
  endfunction

  // compare outputs with the model; called away from the clock edge
  task automatic check_all();
    chk("R2", "pop_valid", 32'(pop_valid), 32'(q.size() > 0));
    if (q.size() > 0) chk("R2", "pop_data", pop_data, q[0]);
    chk("R9", "fifo_full", 32'(fifo_full), 32'(q.size() == DEPTH));
    chk("R9", "fifo_empty", 32'(fifo_empty), 32'(q.size() == 0));
    chk("R4", "half_empty", 32'(half_empty), 32'(exp_half(q.size())));
    chk("R8", "busy", 32'(busy), 32'(m_busy));
    chk("R6", "dwords_left", 32'(dwords_left), 32'(m_left));
  endtask

  // one cycle: drive at negedge, advance the model, wait for the edge, check at the next negedge
  task automatic cyc(input bit w, input logic [31:0] d, input bit act, input bit st,
                     input int need, input bit rdy, input bit pend);
    bit acc, pf;
    wr_en = w; wr_data = d; xfer_active = act; xfer_start = st;
    xfer_need = LEFT_W'(need); pop_ready = rdy; next_pend = pend;
    if (st) begin
      q.delete();
      m_left = need;
    end else begin
      acc = w && act && m_left > 0 && q.size() < DEPTH;
      pf  = rdy && q.size() > 0;
      if (pf) void'(q.pop_front());
      if (acc) begin
        q.push_back(d);
        m_left--;
      end
    end
    m_busy = pend;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "empty in reset", 32'(fifo_empty), 32'd1);
    chk("R1", "valid in reset", 32'(pop_valid), 32'd0);
    chk("R1", "half in reset", 32'(half_empty), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "full after reset", 32'(fifo_full), 32'd0);
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "left after reset", 32'(dwords_left), 32'd0);

    // R5: writes with no transfer active are ignored
    cyc(1, 32'hDEAD0001, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 30, 0, 0);
    cyc(1, 32'hDEAD0002, 0, 0, 0, 0, 0);
    chk("R5", "inactive write ignored", 32'(fifo_empty), 32'd1);

    // R3/R4: fill past full with no pops; the extra writes are dropped
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 32'hA000_0000 + i, 1, 0, 0, 0, 0);
    chk("R3", "full after overfill", 32'(fifo_full), 32'd1);
    chk("R3", "dropped writes keep left", 32'(dwords_left), 32'd14);
    // R3: write and pop in the same full cycle; the write is still dropped
    cyc(1, 32'hBBBB_BBBB, 1, 0, 0, 1, 0);
    chk("R3", "write during full pop dropped", 32'(fifo_full), 32'd0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 1, 0);
    chk("R4", "half at threshold", 32'(half_empty), 32'd1);

    // R7: start with a simultaneous write and pop flushes everything
    cyc(1, 32'hCCCC_0000, 1, 1, 3, 1, 1);
    chk("R7", "flush empties", 32'(fifo_empty), 32'd1);
    chk("R8", "busy follows pend", 32'(busy), 32'd1);

    // R6: surplus writes beyond the need are discarded
    for (int i = 0; i < 6; i++) cyc(1, 32'hE000_0000 + i, 1, 0, 0, 0, 0);
    chk("R6", "only needed dwords kept", 32'(fifo_full | fifo_empty), 32'd0);
    chk("R6", "left reaches zero", 32'(dwords_left), 32'd0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 1, 0);
    chk("R6", "surplus not stored", 32'(fifo_empty), 32'd1);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pw, pr, pa;
      pw = 20 + $urandom_range(0, 75);
      pr = 5 + $urandom_range(0, 90);
      pa = 60 + $urandom_range(0, 40);
      for (int c = 0; c < 300; c++) begin
        bit st;
        st = ($urandom_range(0, 99) < 2);
        cyc($urandom_range(0, 99) < pw, $urandom(), $urandom_range(0, 99) < pa, st,
            $urandom_range(0, 40), $urandom_range(0, 99) < pr, $urandom_range(0, 99) < 10);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule